// File: doc/BRIEF.md
# Low-Voltage Detect Control Register

This block is an 8-bit memory-mapped status and control register that sits beside a supply-voltage detector. It captures a low-voltage event in a sticky flag and turns that flag into an interrupt request, a reset request, or both. Software picks which one through enable bits and clears the flag by writing an acknowledge bit. While the device is stopped, the register can also hold back wake-up requests until the supply has climbed back above its re-arm level.

Two reset inputs shape its state. A power-on reset loads the register with the reset-request enable set. A general reset, which includes one caused by the detector's own reset request, clears everything except that enable. The reset-request enable can be written only once after either reset. The first write access to the register closes it, whatever value that write carries. The analog comparator and the stop/clock controller are outside this block. Its inputs are assumed to be synchronous to `clk`.

Top module: `lvd_ctrl_reg`

## Requirements
- R1: After power-on reset the register reads 0x08: reset-request enable (bit 3) is 1, and `irq` and `rst_req` are 0.
- R2: A general reset clears the flag (bit 7), interrupt enable (bit 5) and wake-block enable (bit 4). It leaves the reset-request enable (bit 3) at its prior value and reopens it for one write.
- R3: The event flag (bit 7) is set by `lv_evt` only in a cycle where `det_en` is 1. With `det_en` at 0 the flag is unchanged.
- R4: A write with bit 6 set clears the flag. Bit 6 and bits 2..0 always read as 0, and writes to bits 2..0 have no effect.
- R5: When `lv_evt` with `det_en` and an acknowledge write fall in the same cycle, the flag ends up set.
- R6: `irq` is 1 exactly while the flag and interrupt enable (bit 5) are both 1. With bit 5 at 0, the flag is visible only by reading it.
- R7: `rst_req` is 1 exactly while the flag and the reset-request enable (bit 3) are both 1.
- R8: The first write access after any reset loads bit 3 from write data and locks it. Later writes leave bit 3 unchanged while still updating bits 5 and 4.
- R9: `wake` is 1 when `in_stop` and `wake_req` are both 1, unless wake-block (bit 4) is 1 and `above_rearm` is 0.
- R10: The flag is read-only. Writing 1 to bit 7 does not set it.
- R11: `rdata` shows the register only while `sel` and `rd` are both 1, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous assert, active low |
| rst_n | input | 1 | General reset, asynchronous assert, active low |
| sel | input | 1 | Register select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| lv_evt | input | 1 | Low-voltage event from the detector |
| det_en | input | 1 | Detector enable |
| above_rearm | input | 1 | Supply is above the re-arm level |
| in_stop | input | 1 | Device is in stop mode |
| wake_req | input | 1 | Pending interrupt or reset asking to wake |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | Reset request |
| wake | output | 1 | Gated wake signal |

## Verification
Register-bit and flag changes come from a write or event driven before a rising edge, and they appear on `rdata`, `irq` and `rst_req` right after that edge. The bench therefore drives every stimulus on a falling edge and lets one rising edge pass. It then removes the stimulus and samples on the next falling edge. `rdata` and `wake` are combinational, so they are checked in the same half-cycle in which their inputs are driven. Reset values are read back one falling edge after the reset input is released.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_FLAG = 7;
  localparam int BIT_ACK  = 6;
  localparam int BIT_IE   = 5;
  localparam int BIT_SAFE = 4;
  localparam int BIT_REN  = 3;
  localparam int RSV_W    = 3;

  typedef struct packed {
    logic ie;
    logic safe;
    logic ren;
  } lvd_cfg_t;
endpackage

// File: rtl/lvd_event_flag.sv
module lvd_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = 1'b1;
    else if (ack_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_evt_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !set_i) |=> !flag_q);
  assert_flag_needs_evt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !flag_q) |=> !flag_q);
endmodule

// File: rtl/lvd_cfg_bits.sv
module lvd_cfg_bits
  import lvd_pkg::*;
(
  input  logic     clk,
  input  logic     por_n,
  input  logic     any_rst_n,
  input  logic     wr_i,
  input  lvd_cfg_t wcfg_i,
  output lvd_cfg_t cfg_o
);
  logic ie_q, ie_d, safe_q, safe_d, ren_q, ren_d, lock_q, lock_d;
  logic ren_we;

  assign ren_we = wr_i && !lock_q;

  always_comb begin
    ie_d   = ie_q;
    safe_d = safe_q;
    ren_d  = ren_q;
    lock_d = lock_q;
    if (wr_i) begin
      ie_d   = wcfg_i.ie;
      safe_d = wcfg_i.safe;
      lock_d = 1'b1;
    end
    if (ren_we) ren_d = wcfg_i.ren;
  end

  always_ff @(posedge clk or negedge any_rst_n) begin
    if (!any_rst_n) begin
      ie_q   <= 1'b0;
      safe_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      ie_q   <= ie_d;
      safe_q <= safe_d;
      lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      ren_q <= 1'b1;
    else if (ren_we) ren_q <= ren_d;
  end

  assign cfg_o = '{ie: ie_q, safe: safe_q, ren: ren_q};

  assert_ren_locked_R8: assert property (@(posedge clk) disable iff (!any_rst_n)
    lock_q |=> $stable(ren_q));
  assert_first_write_loads_R8: assert property (@(posedge clk) disable iff (!any_rst_n)
    (wr_i && !lock_q) |=> (ren_q == $past(wcfg_i.ren)));
endmodule

// File: rtl/lvd_wake_gate.sv
module lvd_wake_gate (
  input  logic in_stop_i,
  input  logic wake_req_i,
  input  logic safe_i,
  input  logic above_i,
  output logic wake_o
);
  logic pass;

  always_comb begin
    pass   = !safe_i || above_i;
    wake_o = in_stop_i && wake_req_i && pass;
  end
endmodule

// File: rtl/lvd_ctrl_reg.sv
module lvd_ctrl_reg
  import lvd_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          lv_evt,
  input  logic          det_en,
  input  logic          above_rearm,
  input  logic          in_stop,
  input  logic          wake_req,
  output logic          irq,
  output logic          rst_req,
  output logic          wake
);
  localparam int RSV_MSB = RSV_W - 1;

  logic          any_rst_n;
  logic          wr_acc, rd_acc;
  logic          ev_set, ack;
  logic          flag;
  lvd_cfg_t      wcfg, cfg;
  logic [DW-1:0] img;

  assign any_rst_n = por_n && rst_n;
  assign wr_acc    = sel && wr;
  assign rd_acc    = sel && rd;
  assign ev_set    = lv_evt && det_en;
  assign ack       = wr_acc && wdata[BIT_ACK];
  assign wcfg      = '{ie: wdata[BIT_IE], safe: wdata[BIT_SAFE], ren: wdata[BIT_REN]};

  lvd_event_flag u_flag (
    .clk   (clk),
    .rst_n (any_rst_n),
    .set_i (ev_set),
    .ack_i (ack),
    .flag_o(flag)
  );

  lvd_cfg_bits u_cfg (
    .clk      (clk),
    .por_n    (por_n),
    .any_rst_n(any_rst_n),
    .wr_i     (wr_acc),
    .wcfg_i   (wcfg),
    .cfg_o    (cfg)
  );

  lvd_wake_gate u_wake (
    .in_stop_i (in_stop),
    .wake_req_i(wake_req),
    .safe_i    (cfg.safe),
    .above_i   (above_rearm),
    .wake_o    (wake)
  );

  always_comb begin
    img           = '0;
    img[BIT_FLAG] = flag;
    img[BIT_IE]   = cfg.ie;
    img[BIT_SAFE] = cfg.safe;
    img[BIT_REN]  = cfg.ren;
    rdata         = rd_acc ? img : '0;
  end

  assign irq     = flag && cfg.ie;
  assign rst_req = flag && cfg.ren;

  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!any_rst_n)
    irq |-> (flag && cfg.ie));
  assert_rr_needs_flag_R7: assert property (@(posedge clk) disable iff (!any_rst_n)
    rst_req |-> flag);
  assert_wake_blocked_R9: assert property (@(posedge clk) disable iff (!any_rst_n)
    (cfg.safe && !above_rearm) |-> !wake);
  assert_flag_ro_R10: assert property (@(posedge clk) disable iff (!any_rst_n)
    (wr_acc && wdata[BIT_FLAG] && !flag && !ev_set) |=> !flag);
  assert_rsv_zero_R4: assert property (@(posedge clk) disable iff (!any_rst_n)
    (wr_acc && (|wdata[RSV_MSB:0])) |=> (img[RSV_MSB:0] == '0));
  assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!any_rst_n)
    !rd_acc |-> (rdata == '0));
endmodule

// File: tb/sim_lvd_ctrl_reg.sv
`timescale 1ns/1ps
module sim_lvd_ctrl_reg;
  logic       clk = 1'b0;
  logic       por_n, rst_n, sel, rd, wr;
  logic [7:0] wdata, rdata;
  logic       lv_evt, det_en, above_rearm, in_stop, wake_req;
  logic       irq, rst_req, wake;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  lvd_ctrl_reg u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .lv_evt(lv_evt), .det_en(det_en),
    .above_rearm(above_rearm), .in_stop(in_stop), .wake_req(wake_req),
    .irq(irq), .rst_req(rst_req), .wake(wake)
  );

  typedef struct packed {
    logic       w;
    logic [7:0] wd;
    logic       ev;
    logic       en;
    logic [7:0] exp_rd;
    logic       exp_irq;
    logic       exp_rr;
  } vec_t;

  // Walked right after power-on reset (0x08, bit 3 still writable).
  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h08, 1'b0, 1'b0},  // R3 no set without det_en
    '{1'b1, 8'h20, 1'b0, 1'b0, 8'h20, 1'b0, 1'b0},  // R8 first write clears bit3, locks
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'hA0, 1'b1, 1'b0},  // R3 R6 flag set, irq
    '{1'b1, 8'h60, 1'b0, 1'b0, 8'h20, 1'b0, 1'b0},  // R4 ack clears
    '{1'b1, 8'h60, 1'b1, 1'b1, 8'hA0, 1'b1, 1'b0},  // R5 event beats ack
    '{1'b1, 8'h08, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0},  // R8 locked, R6 polling
    '{1'b1, 8'h47, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},  // R4 ack, reserved ignored
    '{1'b1, 8'h90, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0}   // R10 flag read-only
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    sel = 0; rd = 0; wr = 0; wdata = '0; lv_evt = 0; det_en = 0;
  endtask

  // Drive on falling edge, let one rising edge pass, release, return at falling edge.
  task automatic cyc(input logic w, input logic [7:0] wd, input logic ev, input logic en);
    @(negedge clk);
    sel = w; wr = w; wdata = wd; lv_evt = ev; det_en = en;
    @(negedge clk);
    idle();
  endtask

  task automatic rd_reg(output logic [7:0] v);
    sel = 1; rd = 1;
    #0.5 v = rdata;
    sel = 0; rd = 0;
  endtask

  task automatic do_reset(input bit por);
    @(negedge clk);
    if (por) por_n = 0; else rst_n = 0;
    repeat (2) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    por_n = 1; rst_n = 1; above_rearm = 0; in_stop = 0; wake_req = 0;
    idle();
    do_reset(1'b1);
    rd_reg(v);
    chk("R1 por value", v, 8'h08);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rst_req", {7'd0, rst_req}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].w, VEC[i].wd, VEC[i].ev, VEC[i].en);
      rd_reg(v);
      chk($sformatf("vector %0d rdata", i), v, VEC[i].exp_rd);
      chk($sformatf("vector %0d irq R6", i), {7'd0, irq}, {7'd0, VEC[i].exp_irq});
      chk($sformatf("vector %0d rst_req R7", i), {7'd0, rst_req}, {7'd0, VEC[i].exp_rr});
    end

    // R7 reset request, then R2 general reset keeps bit 3
    do_reset(1'b1);
    cyc(1, 8'h28, 0, 0);
    cyc(0, 8'h00, 1, 1);
    rd_reg(v);
    chk("R7 flag with ren", v, 8'hA8);
    chk("R7 rst_req high", {7'd0, rst_req}, 8'h01);
    chk("R6 irq high", {7'd0, irq}, 8'h01);
    do_reset(1'b0);
    rd_reg(v);
    chk("R2 general reset keeps ren", v, 8'h08);
    chk("R2 rst_req low", {7'd0, rst_req}, 8'h00);
    cyc(1, 8'h00, 0, 0);
    rd_reg(v);
    chk("R2 R8 lock released by general reset", v, 8'h00);
    do_reset(1'b0);
    rd_reg(v);
    chk("R2 ren zero kept", v, 8'h00);

    // R9 wake gating
    cyc(1, 8'h10, 0, 0);
    @(negedge clk);
    in_stop = 1; wake_req = 1; above_rearm = 0;
    #0.5 chk("R9 blocked below rearm", {7'd0, wake}, 8'h00);
    above_rearm = 1;
    #0.5 chk("R9 pass above rearm", {7'd0, wake}, 8'h01);
    cyc(1, 8'h00, 0, 0);
    above_rearm = 0;
    #0.5 chk("R9 safe off passes", {7'd0, wake}, 8'h01);
    wake_req = 0;
    #0.5 chk("R9 no request no wake", {7'd0, wake}, 8'h00);
    in_stop = 0; wake_req = 1;
    #0.5 chk("R9 not stopped no wake", {7'd0, wake}, 8'h00);
    wake_req = 0;

    // R11 read gating
    cyc(1, 8'h30, 0, 0);
    @(negedge clk);
    sel = 0; rd = 1;
    #0.5 chk("R11 no select", rdata, 8'h00);
    sel = 1; rd = 0;
    #0.5 chk("R11 no read", rdata, 8'h00);
    sel = 1; rd = 1;
    #0.5 chk("R11 selected read", rdata, 8'h30);
    idle();

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule